// File: doc/BRIEF.md
# Prescaled Multi-Channel Reload Timer

This unit contains two or three independent 32-bit down-counters behind a word-addressed register interface with a single write strobe and a combinational read port. Each channel has a reload value, a live count and a control word. The control word picks a prescale ratio, enables an interrupt and carries a sticky underflow flag. When a running channel passes zero, it takes its count back from the reload value and raises the flag. The interrupt line of each channel follows that flag, gated by the enable bit.

A single free-running prescaler serves every channel. A shared run register starts and stops each channel on its own. Two more registers are plain storage: a one-bit output-control register, and a capture register that exists only when there are three channels. Software sets the reload value, loads the count, programs the control word and then sets the channel's run bit.

Top module: `tri_reload_timer`

## Requirements
- R1: After reset, every channel's reload and count registers read 0xFFFFFFFF. The control words, the run register, the output-control register and the capture register read 0, and every irq line is low.
- R2: The prescaler is a 10-bit counter. It is 0 at reset and adds 1 every clock. For control code k in bits [2:0], k = 0 to 4, a count step is allowed in each cycle where the low 2k+2 bits of the prescaler are all ones. That gives rates of clk/4, /16, /64, /256 and /1024. Codes 5, 6 and 7 give no steps, because an external clock is not modelled.
- R3: A running channel subtracts 1 from its count on each allowed step. If the count is 0 on such a step, the count is loaded from the reload register instead, and the underflow flag (control bit 8) is set.
- R4: irq[n] is 1 exactly while channel n's underflow flag (bit 8) and its interrupt-enable bit (bit 5) are both 1.
- R5: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag as it was.
- R6: Bit n of the run register (offset 0x04) runs channel n when 1 and stops it when 0. A stopped channel keeps its count unchanged. A new run value applies from the clock after the write.
- R7: A control write stores bits [7:0]. Reads return those bits, the current flag in bit 8, and 0 in bits [31:9]. The channel takes no count step in the cycle of its control write.
- R8: A count write sets the count at the next clock edge. It takes priority over a step or a reload in that cycle.
- R9: Address map (byte offsets): output control at 0x00, keeping bit 0 only; run register at 0x04. Channel blocks start at 0x08, 0x14 and 0x20. Within a block, reload is at +0x0, count at +0x4 and control at +0x8. The capture register is at 0x2C and is a plain 32-bit register. Any other offset reads 0.
- R10: A reload-register write does not change the count. The new value is used at the next underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 6 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
Every write lands at the clock edge that ends its cycle. Because read data and interrupt lines are combinational from registered state, the effect of a write is visible in the very next cycle. The bench drives inputs and samples outputs at the falling edge. A reference model in the bench advances on the rising edge, using the inputs held since the falling edge. Each sample therefore compares the design and the model after the same number of edges. Prescaler phase, lost steps on control writes, and the priority of count writes all follow from that per-edge update.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int DW        = 32;
    parameter int CTL_W     = 8;
    parameter int PSEL_W    = 3;
    parameter int UNIE_BIT  = 5;
    parameter int UNF_BIT   = 8;

    parameter int OFF_OCR   = 0;
    parameter int OFF_START = 4;
    parameter int CH_BASE   = 8;
    parameter int CH_STRIDE = 12;
    parameter int OFF_RLD   = 0;
    parameter int OFF_CNT   = 4;
    parameter int OFF_CTL   = 8;
    parameter int OFF_CAP   = 12;

    typedef struct packed {
        logic [DW-1:0]    rld;
        logic [DW-1:0]    cnt;
        logic [CTL_W-1:0] ctl;
        logic             unf;
    } ch_st_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int NUM_PSC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_PSC-1:0] tick_o
);
    localparam int PW = 2 * NUM_PSC;

    logic [PW-1:0] psc_d, psc_q;

    always_comb begin
        psc_d = psc_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    for (genvar k = 0; k < NUM_PSC; k++) begin : g_tick
        assign tick_o[k] = &psc_q[2*k+1:0];
    end

    // R2: each slower step coincides with every faster one
    for (genvar k = 1; k < NUM_PSC; k++) begin : g_chk
        a_r2_tick_nested: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[k] |-> tick_o[k-1]);
    end

    // R2: the fastest step is never two cycles in a row
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int NUM_PSC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rld_we,
    input  logic               cnt_we,
    input  logic               ctl_we,
    input  logic [DW-1:0]      wdata,
    input  logic               run_i,
    input  logic [NUM_PSC-1:0] tick_i,
    output logic [DW-1:0]      rld_o,
    output logic [DW-1:0]      cnt_o,
    output logic [DW-1:0]      ctl_o,
    output logic               irq_o
);
    localparam int RD_PAD = DW - CTL_W - 1;

    ch_st_t s_d, s_q;
    logic   tick_sel;
    logic   step;

    always_comb begin
        tick_sel = 1'b0;
        for (int k = 0; k < NUM_PSC; k++) begin
            if (s_q.ctl[PSEL_W-1:0] == PSEL_W'(k)) tick_sel = tick_i[k];
        end
        step = run_i && tick_sel && !ctl_we;

        s_d = s_q;
        if (rld_we) s_d.rld = wdata;
        if (ctl_we) begin
            s_d.ctl = wdata[CTL_W-1:0];
            if (!wdata[UNF_BIT]) s_d.unf = 1'b0;
        end
        if (cnt_we) begin
            s_d.cnt = wdata;
        end else if (step) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = s_q.rld;
                s_d.unf = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.rld <= '1;
            s_q.cnt <= '1;
            s_q.ctl <= '0;
            s_q.unf <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rld_o = s_q.rld;
    assign cnt_o = s_q.cnt;
    assign ctl_o = {{RD_PAD{1'b0}}, s_q.unf, s_q.ctl};
    assign irq_o = s_q.unf && s_q.ctl[UNIE_BIT];

    // R3: passing zero reloads and flags
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_we && s_q.cnt == '0) |=> (s_q.cnt == $past(s_q.rld)) && s_q.unf);

    // R5: the flag only drops through a control write carrying 0 in bit 8
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.unf) |-> $past(ctl_we && !wdata[UNF_BIT]));

    // R6: a stopped channel holds its count
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_we) |=> $stable(s_q.cnt));

    // R8: a count write lands at the next edge
    a_r8_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (s_q.cnt == $past(wdata)));

    // R7: no step in the cycle of a control write
    a_r7_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !cnt_we) |=> $stable(s_q.cnt));
endmodule

// File: rtl/tri_reload_timer.sv
module tri_reload_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int NUM_PSC = 5,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic HAS_CAP = (NUM_CH > 2);
    localparam logic [ADDR_W-1:0] A_OCR   = ADDR_W'(OFF_OCR);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
    localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(CH_BASE + 2 * CH_STRIDE + OFF_CAP);

    function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input int off);
        return ADDR_W'(CH_BASE + ch * CH_STRIDE + off);
    endfunction

    typedef struct packed {
        logic              ocr;
        logic [NUM_CH-1:0] run;
        logic [DW-1:0]     cap;
    } top_st_t;

    top_st_t            s_d, s_q;
    logic [NUM_PSC-1:0] tick;
    logic [NUM_CH-1:0]  rld_we, cnt_we, ctl_we;
    logic [DW-1:0]      rld_rd [NUM_CH];
    logic [DW-1:0]      cnt_rd [NUM_CH];
    logic [DW-1:0]      ctl_rd [NUM_CH];

    tmr_prescaler #(.NUM_PSC(NUM_PSC)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign rld_we[ch] = wr_en && (addr == reg_addr(ch, OFF_RLD));
        assign cnt_we[ch] = wr_en && (addr == reg_addr(ch, OFF_CNT));
        assign ctl_we[ch] = wr_en && (addr == reg_addr(ch, OFF_CTL));

        tmr_channel #(.NUM_PSC(NUM_PSC)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .rld_we (rld_we[ch]),
            .cnt_we (cnt_we[ch]),
            .ctl_we (ctl_we[ch]),
            .wdata  (wdata),
            .run_i  (s_q.run[ch]),
            .tick_i (tick),
            .rld_o  (rld_rd[ch]),
            .cnt_o  (cnt_rd[ch]),
            .ctl_o  (ctl_rd[ch]),
            .irq_o  (irq[ch])
        );

        // R4: an interrupt is never raised without the flag and enable seen on readback
        a_r4_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[ch] |-> (ctl_rd[ch][UNF_BIT] && ctl_rd[ch][UNIE_BIT]));
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (addr == A_OCR)               s_d.ocr = wdata[0];
            if (addr == A_START)             s_d.run = wdata[NUM_CH-1:0];
            if (HAS_CAP && (addr == A_CAP))  s_d.cap = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_OCR)              rdata[0] = s_q.ocr;
        if (addr == A_START)            rdata[NUM_CH-1:0] = s_q.run;
        if (HAS_CAP && (addr == A_CAP)) rdata = s_q.cap;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == reg_addr(ch, OFF_RLD)) rdata = rld_rd[ch];
            if (addr == reg_addr(ch, OFF_CNT)) rdata = cnt_rd[ch];
            if (addr == reg_addr(ch, OFF_CTL)) rdata = ctl_rd[ch];
        end
    end

    // R9: the output-control register exposes a single bit
    a_r9_ocr_width: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_OCR) |-> (rdata[DW-1:1] == '0));
endmodule

// File: tb/tri_reload_timer_tb.sv
module tri_reload_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    always #5 clk = ~clk;

    tri_reload_timer u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (we),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // reference model
    logic [31:0] m_rld [3];
    logic [31:0] m_cnt [3];
    logic [7:0]  m_ctl [3];
    logic        m_unf [3];
    logic [2:0]  m_run;
    logic        m_ocr;
    logic [31:0] m_cap;
    logic [9:0]  m_psc;
    logic [4:0]  m_tk;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_rld[i] = '1; m_cnt[i] = '1; m_ctl[i] = '0; m_unf[i] = 1'b0;
            end
            m_run = '0; m_ocr = 1'b0; m_cap = '0; m_psc = '0;
        end else begin
            for (int k = 0; k < 5; k++) begin
                m_tk[k] = ((m_psc & ((10'd1 << (2*k+2)) - 10'd1)) == ((10'd1 << (2*k+2)) - 10'd1));
            end
            for (int i = 0; i < 3; i++) begin
                logic [5:0] b;
                logic       tk, cw;
                b  = 6'(8 + 12*i);
                tk = (m_ctl[i][2:0] < 3'd5) ? m_tk[m_ctl[i][2:0]] : 1'b0;
                cw = we && (addr == b + 6'd8);
                if (we && addr == b + 6'd4) m_cnt[i] = wdata;
                else if (m_run[i] && tk && !cw) begin
                    if (m_cnt[i] == 0) begin m_cnt[i] = m_rld[i]; m_unf[i] = 1'b1; end
                    else m_cnt[i] = m_cnt[i] - 1;
                end
                if (we && addr == b) m_rld[i] = wdata;
                if (cw) begin
                    m_ctl[i] = wdata[7:0];
                    if (!wdata[8]) m_unf[i] = 1'b0;
                end
            end
            if (we && addr == 6'h04) m_run = wdata[2:0];
            if (we && addr == 6'h00) m_ocr = wdata[0];
            if (we && addr == 6'h2C) m_cap = wdata;
            m_psc = m_psc + 10'd1;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 6'h00) r = {31'b0, m_ocr};
        if (a == 6'h04) r = {29'b0, m_run};
        if (a == 6'h2C) r = m_cap;
        for (int i = 0; i < 3; i++) begin
            if (a == 6'(8 + 12*i))  r = m_rld[i];
            if (a == 6'(12 + 12*i)) r = m_cnt[i];
            if (a == 6'(16 + 12*i)) r = {23'b0, m_unf[i], m_ctl[i]};
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 3; i++) r[i] = m_unf[i] && m_ctl[i][5];
        return r;
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        if (a == 6'h04) return "R6";
        if (a == 6'h0C || a == 6'h18 || a == 6'h24) return "R3";
        if (a == 6'h10 || a == 6'h1C || a == 6'h28) return "R5";
        if (a == 6'h08 || a == 6'h14 || a == 6'h20) return "R10";
        return "R9";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (addr 0x%02h)", tag, act, exp, addr);
        end
    endtask

    task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        chk(cur_tag, rdata, exp_rd(addr));
        chk("R4", {29'b0, irq}, exp_irq());
        we = w; addr = a; wdata = d; cur_tag = tag;
    endtask

    task automatic rd(input logic [5:0] a, input string tag, input int n);
        for (int i = 0; i < n; i++) step(1'b0, a, '0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int a = 0; a < 64; a += 4) rd(6'(a), "R1", 1);
        // R2: code 0 on channel 0, small reload
        step(1'b1, 6'h08, 32'd5, "R10");
        step(1'b1, 6'h0C, 32'd5, "R8");
        step(1'b1, 6'h10, 32'h20, "R7");
        step(1'b1, 6'h04, 32'h1, "R6");
        rd(6'h0C, "R2", 40);
        rd(6'h10, "R3", 4);
        // R2: code 1 and code 5 on channel 1
        step(1'b1, 6'h18, 32'd3, "R8");
        step(1'b1, 6'h1C, 32'h21, "R7");
        step(1'b1, 6'h04, 32'h3, "R6");
        rd(6'h18, "R2", 80);
        step(1'b1, 6'h1C, 32'h5, "R7");
        rd(6'h18, "R2", 60);
        // R5: write 1 keeps the flag, write 0 clears it
        step(1'b1, 6'h10, 32'h120, "R5");
        rd(6'h10, "R5", 2);
        step(1'b1, 6'h10, 32'h000, "R5");
        rd(6'h10, "R5", 2);
        // R7: upper bits written as ones read back as zero
        step(1'b1, 6'h1C, 32'hFFFF_FE22, "R7");
        rd(6'h1C, "R7", 2);
        // R8: count write while running on channel 2
        step(1'b1, 6'h28, 32'h0, "R7");
        step(1'b1, 6'h04, 32'h7, "R6");
        step(1'b1, 6'h24, 32'd2, "R8");
        rd(6'h24, "R8", 12);
        // R10: new reload does not disturb the count
        step(1'b1, 6'h08, 32'd9, "R10");
        rd(6'h0C, "R10", 30);
        // R6: stop all, counts freeze
        step(1'b1, 6'h04, 32'h0, "R6");
        rd(6'h0C, "R6", 10);
        rd(6'h24, "R6", 10);
        // R9: one-bit output control, capture storage, unmapped offsets
        step(1'b1, 6'h00, 32'hFFFF_FFFF, "R9");
        rd(6'h00, "R9", 1);
        step(1'b1, 6'h2C, 32'hA5A5_0F0F, "R9");
        rd(6'h2C, "R9", 1);
        rd(6'h30, "R9", 1);
        rd(6'h3C, "R9", 1);
        // constrained random
        for (int n = 0; n < 20000; n++) begin
            logic [5:0]  a;
            logic [31:0] d;
            a = 6'(($urandom % 16) * 4);
            if (($urandom % 10) < 4) begin
                rd(a, tag_of(a), 1);
            end else begin
                d = $urandom;
                if (a == 6'h08 || a == 6'h14 || a == 6'h20 ||
                    a == 6'h0C || a == 6'h18 || a == 6'h24) d = $urandom % 40;
                if (a == 6'h10 || a == 6'h1C || a == 6'h28)
                    d = {$urandom % 65536} & 32'hFFF8 |
                        ((($urandom % 4) == 0) ? ($urandom % 8) : ($urandom % 2));
                step(1'b1, a, d, tag_of(a));
            end
        end
        rd(6'h00, "R9", 1);
        finish_run();
    end
endmodule